// File: doc/BRIEF.md
# DMA Channel Command and Status Register Bank

This block is the register slave of a multi-channel DMA engine. It holds four per-channel bitmaps for up to 32 channels: hardware request enable, error-interrupt enable, transfer-interrupt pending and error pending. It also holds a global control word and an error status word. Software does not read, modify and write the bitmaps. It writes a channel number to a byte-wide command port, and that one change happens in a single bus cycle. Two further command ports send one-cycle pulses to the channel datapath: one starts a channel in software, one clears its done flag.

The channel datapath reports finished transfers and errors on per-channel event inputs, and these set the pending bits. The block combines the pending bits into a transfer interrupt and a masked error interrupt. A strap input selects big-endian register layout. In that mode byte and halfword addresses are swapped inside the word, and the data lanes are reordered, so a big-endian host sees every register in its natural order.

Top module: `dma_chctl_regs`

## Requirements
- R1: After reset every bitmap, the control word, the error status word, all interrupt outputs and all pulse outputs are zero.
- R2: A byte write to 0x1B sets, and a byte write to 0x1A clears, the request-enable bit of the channel named by bits 4:0 of the byte. Bits 7:5 are ignored, and no other channel's bit changes. The request-enable bitmap reads at 0x0C and drives `req_enable`. A channel number at or above NUM_CH has no effect.
- R3: A byte write to 0x19 sets, and a byte write to 0x18 clears, the error-interrupt-enable bit of the named channel. The bitmap reads at 0x14.
- R4: `hw_done_evt[n]` sets interrupt-pending bit n (read at 0x24). `hw_err_evt[n]` sets error-pending bit n (read at 0x2C). A byte write of n to 0x1F clears interrupt-pending bit n, and a byte write of n to 0x1E clears error-pending bit n. An event in the same cycle as the clear of the same bit leaves the bit set.
- R5: A byte write of n to 0x1D raises `start_pulse[n]`, and a byte write of n to 0x1C raises `done_clear_pulse[n]`. Each pulse is high for exactly the one cycle after the write edge.
- R6: Word writes load the control word (0x00), request enable (0x0C) and error-interrupt enable (0x14). The following are ignored: word writes to any other offset, byte or halfword writes to those three registers, halfword writes to the command ports, accesses with size code 3, and writes to unmapped offsets.
- R7: The control word keeps only these bits: 1 debug enable, 2 round-robin channel arbitration, 3 round-robin group arbitration, 4 halt on error, 5 halt, 6 continuous link, 7 minor-loop mapping, 16 cancel with error, 17 cancel. Each bit drives its own output, and all other bits read as zero.
- R8: Size codes are 0 byte, 1 halfword and 2 word. When `big_endian` is high, a word access has its data byte-swapped. A byte access uses address XOR 3. A halfword access uses address XOR 2 and has its two data bytes swapped. Reads and writes follow the same mapping.
- R9: `irq_xfer` is high while any interrupt-pending bit is set. `irq_err` is high while any error-pending bit has its error-interrupt enable set.
- R10: The error status word at 0x04 has bit 31 set while any error-pending bit is set. Bits 4:0 hold the lowest channel index of the most recent cycle that carried an error event.
- R11: An error event in a cycle when halt on error is already set sets the halt bit.
- R12: Reads return the addressed lanes of the mapped registers. Reads of the command ports (0x18 to 0x1F) and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | Big-endian register layout strap |
| bus_valid | input | 1 | Access valid this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned, combinational |
| hw_done_evt | input | NUM_CH | Per-channel transfer-done events |
| hw_err_evt | input | NUM_CH | Per-channel error events |
| req_enable | output | NUM_CH | Hardware request enables |
| start_pulse | output | NUM_CH | Software start pulses |
| done_clear_pulse | output | NUM_CH | Done-flag clear pulses |
| dbg_enable | output | 1 | Control bit 1 |
| arb_rr_chan | output | 1 | Control bit 2 |
| arb_rr_group | output | 1 | Control bit 3 |
| halt_on_error | output | 1 | Control bit 4 |
| halted | output | 1 | Control bit 5 |
| cont_link | output | 1 | Control bit 6 |
| minor_map_en | output | 1 | Control bit 7 |
| cancel_err_req | output | 1 | Control bit 16 |
| cancel_req | output | 1 | Control bit 17 |
| irq_xfer | output | 1 | Transfer interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The assertions assume one access per cycle. They also assume that a change of more than one request-enable bit can only come from a word load of that register, so the bench never sets or clears the bitmap through any other path. They assume the event inputs are sampled as levels once per cycle, so the bench drives events as one-cycle pulses away from the clock edge, and it places same-cycle collisions between events and clear commands on purpose. The halt-on-error property relies on the registered control value from the previous cycle, and the bench enables halt on error one full write before it raises the error event.

// File: rtl/dma_chctl_pkg.sv
package dma_chctl_pkg;

    localparam int CH_IDX_W = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    // word indices (byte offset / 4)
    localparam int WI_CTRL   = 0;
    localparam int WI_ESTAT  = 1;
    localparam int WI_REQ    = 3;
    localparam int WI_EEI    = 5;
    localparam int WI_CMD_LO = 6;
    localparam int WI_CMD_HI = 7;
    localparam int WI_INT    = 9;
    localparam int WI_ERR    = 11;

    // command port index = byte offset - 0x18
    localparam int CP_CLR_EEI   = 0;
    localparam int CP_SET_EEI   = 1;
    localparam int CP_CLR_REQ   = 2;
    localparam int CP_SET_REQ   = 3;
    localparam int CP_CLR_DONE  = 4;
    localparam int CP_SET_START = 5;
    localparam int CP_CLR_ERR   = 6;
    localparam int CP_CLR_INT   = 7;
    localparam int NUM_CP       = 8;

    // control bit positions
    localparam int CB_DBG     = 1;
    localparam int CB_RR_CH   = 2;
    localparam int CB_RR_GRP  = 3;
    localparam int CB_HOE     = 4;
    localparam int CB_HALT    = 5;
    localparam int CB_CLINK   = 6;
    localparam int CB_MMAP    = 7;
    localparam int CB_CAN_ERR = 16;
    localparam int CB_CANCEL  = 17;

    typedef struct packed {
        logic cancel;
        logic cancel_err;
        logic minor_map;
        logic cont_link;
        logic halt;
        logic halt_on_err;
        logic rr_group;
        logic rr_chan;
        logic dbg_en;
    } ctrl_t;

    function automatic logic [31:0] ctrl_pack(input ctrl_t c);
        logic [31:0] w;
        w             = '0;
        w[CB_DBG]     = c.dbg_en;
        w[CB_RR_CH]   = c.rr_chan;
        w[CB_RR_GRP]  = c.rr_group;
        w[CB_HOE]     = c.halt_on_err;
        w[CB_HALT]    = c.halt;
        w[CB_CLINK]   = c.cont_link;
        w[CB_MMAP]    = c.minor_map;
        w[CB_CAN_ERR] = c.cancel_err;
        w[CB_CANCEL]  = c.cancel;
        return w;
    endfunction

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.dbg_en      = w[CB_DBG];
        c.rr_chan     = w[CB_RR_CH];
        c.rr_group    = w[CB_RR_GRP];
        c.halt_on_err = w[CB_HOE];
        c.halt        = w[CB_HALT];
        c.cont_link   = w[CB_CLINK];
        c.minor_map   = w[CB_MMAP];
        c.cancel_err  = w[CB_CAN_ERR];
        c.cancel      = w[CB_CANCEL];
        return c;
    endfunction

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [15:0] swap16(input logic [15:0] h);
        return {h[7:0], h[15:8]};
    endfunction

endpackage

// File: rtl/dma_chctl_endian.sv
module dma_chctl_endian
    import dma_chctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              big_endian,
    input  acc_size_e         size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [31:0]       word_rdata,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [31:0]       eff_wword,
    output logic [7:0]        eff_wbyte,
    output logic [31:0]       rdata
);

    logic [31:0] lane_shift;
    logic [15:0] half_sel;

    always_comb begin
        eff_addr  = addr;
        eff_wword = wdata;
        eff_wbyte = wdata[7:0];
        unique case (size)
            SZ_BYTE: if (big_endian) eff_addr[1:0] = addr[1:0] ^ 2'b11;
            SZ_HALF: if (big_endian) eff_addr[1]   = ~addr[1];
            SZ_WORD: if (big_endian) eff_wword     = swap32(wdata);
            default: ;
        endcase
    end

    always_comb begin
        lane_shift = word_rdata >> {eff_addr[1:0], 3'b000};
        half_sel   = eff_addr[1] ? word_rdata[31:16] : word_rdata[15:0];
        unique case (size)
            SZ_BYTE: rdata = {24'b0, lane_shift[7:0]};
            SZ_HALF: rdata = {16'b0, big_endian ? swap16(half_sel) : half_sel};
            SZ_WORD: rdata = big_endian ? swap32(word_rdata) : word_rdata;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_chctl_cmd.sv
module dma_chctl_cmd
    import dma_chctl_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic                          fire,
    input  logic [2:0]                    port_idx,
    input  logic [7:0]                    cmd_byte,
    output logic [NUM_CP-1:0][NUM_CH-1:0] cmd_vec
);

    logic [CH_IDX_W-1:0] chan;
    logic [NUM_CH-1:0]   chan_oh;

    assign chan = cmd_byte[CH_IDX_W-1:0];

    // channel numbers at or above NUM_CH match no bit
    always_comb begin
        chan_oh = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(chan) == i) chan_oh[i] = 1'b1;
        end
    end

    for (genvar p = 0; p < NUM_CP; p++) begin : g_port
        assign cmd_vec[p] = (fire && int'(port_idx) == p) ? chan_oh : '0;
    end

endmodule

// File: rtl/dma_chctl_bitmap.sv
module dma_chctl_bitmap #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);

    logic [W-1:0] q_n;

    // set beats clear so a coincident event is never lost
    always_comb begin
        q_n = load_en ? load_val : q;
        q_n = (q_n & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_n;
    end

endmodule

// File: rtl/dma_chctl_regs.sv
module dma_chctl_regs
    import dma_chctl_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              big_endian,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] hw_done_evt,
    input  logic [NUM_CH-1:0] hw_err_evt,
    output logic [NUM_CH-1:0] req_enable,
    output logic [NUM_CH-1:0] start_pulse,
    output logic [NUM_CH-1:0] done_clear_pulse,
    output logic              dbg_enable,
    output logic              arb_rr_chan,
    output logic              arb_rr_group,
    output logic              halt_on_error,
    output logic              halted,
    output logic              cont_link,
    output logic              minor_map_en,
    output logic              cancel_err_req,
    output logic              cancel_req,
    output logic              irq_xfer,
    output logic              irq_err
);

    localparam int WIDX_W = ADDR_W - 2;

    acc_size_e                     size;
    logic [ADDR_W-1:0]             eff_addr;
    logic [31:0]                   eff_wword;
    logic [7:0]                    eff_wbyte;
    logic [31:0]                   word_rdata;
    logic [WIDX_W-1:0]             widx;
    logic                          wr_word;
    logic                          wr_byte;
    logic                          cmd_fire;
    logic [NUM_CP-1:0][NUM_CH-1:0] cmd_vec;
    logic                          load_req;
    logic                          load_eei;
    logic                          load_ctrl;

    logic [NUM_CH-1:0]   req_q;
    logic [NUM_CH-1:0]   eei_q;
    logic [NUM_CH-1:0]   int_q;
    logic [NUM_CH-1:0]   err_q;
    ctrl_t               ctrl_q;
    ctrl_t               ctrl_n;
    logic [CH_IDX_W-1:0] estat_ch_q;
    logic [CH_IDX_W-1:0] err_low;
    logic                any_err_evt;

    assign size = acc_size_e'(bus_size);

    dma_chctl_endian #(.ADDR_W(ADDR_W)) u_endian (
        .big_endian (big_endian),
        .size       (size),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .word_rdata (word_rdata),
        .eff_addr   (eff_addr),
        .eff_wword  (eff_wword),
        .eff_wbyte  (eff_wbyte),
        .rdata      (bus_rdata)
    );

    assign widx     = eff_addr[ADDR_W-1:2];
    assign wr_word  = bus_valid && bus_write && size == SZ_WORD;
    assign wr_byte  = bus_valid && bus_write && size == SZ_BYTE;
    assign cmd_fire = wr_byte && (int'(widx) == WI_CMD_LO || int'(widx) == WI_CMD_HI);

    dma_chctl_cmd #(.NUM_CH(NUM_CH)) u_cmd (
        .fire     (cmd_fire),
        .port_idx ({widx[0], eff_addr[1:0]}),
        .cmd_byte (eff_wbyte),
        .cmd_vec  (cmd_vec)
    );

    assign load_req  = wr_word && int'(widx) == WI_REQ;
    assign load_eei  = wr_word && int'(widx) == WI_EEI;
    assign load_ctrl = wr_word && int'(widx) == WI_CTRL;

    dma_chctl_bitmap #(.W(NUM_CH)) u_req (
        .clk (clk), .rst (rst),
        .load_en (load_req), .load_val (eff_wword[NUM_CH-1:0]),
        .set_vec (cmd_vec[CP_SET_REQ]), .clr_vec (cmd_vec[CP_CLR_REQ]),
        .q (req_q)
    );

    dma_chctl_bitmap #(.W(NUM_CH)) u_eei (
        .clk (clk), .rst (rst),
        .load_en (load_eei), .load_val (eff_wword[NUM_CH-1:0]),
        .set_vec (cmd_vec[CP_SET_EEI]), .clr_vec (cmd_vec[CP_CLR_EEI]),
        .q (eei_q)
    );

    dma_chctl_bitmap #(.W(NUM_CH)) u_int (
        .clk (clk), .rst (rst),
        .load_en (1'b0), .load_val ('0),
        .set_vec (hw_done_evt), .clr_vec (cmd_vec[CP_CLR_INT]),
        .q (int_q)
    );

    dma_chctl_bitmap #(.W(NUM_CH)) u_err (
        .clk (clk), .rst (rst),
        .load_en (1'b0), .load_val ('0),
        .set_vec (hw_err_evt), .clr_vec (cmd_vec[CP_CLR_ERR]),
        .q (err_q)
    );

    // control word with halt forced by an error under halt-on-error
    assign any_err_evt = |hw_err_evt;

    always_comb begin
        ctrl_n = load_ctrl ? ctrl_unpack(eff_wword) : ctrl_q;
        if (ctrl_q.halt_on_err && any_err_evt) ctrl_n.halt = 1'b1;
    end

    always_comb begin
        err_low = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (hw_err_evt[i]) err_low = CH_IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q           <= '0;
            estat_ch_q       <= '0;
            start_pulse      <= '0;
            done_clear_pulse <= '0;
        end else begin
            ctrl_q           <= ctrl_n;
            if (any_err_evt) estat_ch_q <= err_low;
            start_pulse      <= cmd_vec[CP_SET_START];
            done_clear_pulse <= cmd_vec[CP_CLR_DONE];
        end
    end

    always_comb begin
        unique case (int'(widx))
            WI_CTRL:  word_rdata = ctrl_pack(ctrl_q);
            WI_ESTAT: word_rdata = {(|err_q), {(31 - CH_IDX_W){1'b0}}, estat_ch_q};
            WI_REQ:   word_rdata = 32'(req_q);
            WI_EEI:   word_rdata = 32'(eei_q);
            WI_INT:   word_rdata = 32'(int_q);
            WI_ERR:   word_rdata = 32'(err_q);
            default:  word_rdata = '0;
        endcase
    end

    assign req_enable     = req_q;
    assign dbg_enable     = ctrl_q.dbg_en;
    assign arb_rr_chan    = ctrl_q.rr_chan;
    assign arb_rr_group   = ctrl_q.rr_group;
    assign halt_on_error  = ctrl_q.halt_on_err;
    assign halted         = ctrl_q.halt;
    assign cont_link      = ctrl_q.cont_link;
    assign minor_map_en   = ctrl_q.minor_map;
    assign cancel_err_req = ctrl_q.cancel_err;
    assign cancel_req     = ctrl_q.cancel;
    assign irq_xfer       = |int_q;
    assign irq_err        = |(err_q & eei_q);

    // ---------------- assertions ----------------
    AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|hw_done_evt) |=> ((int_q & $past(hw_done_evt)) == $past(hw_done_evt)))
        else $error("done event lost"); // R4

    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        any_err_evt |=> ((err_q & $past(hw_err_evt)) == $past(hw_err_evt)))
        else $error("error event lost"); // R4

    AST_REQ_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
        !load_req |=> ($countones(req_q ^ $past(req_q)) <= 1))
        else $error("request enable changed by more than one bit"); // R2

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_pulse))
        else $error("start pulse not one-hot"); // R5

    AST_DCLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done_clear_pulse))
        else $error("done clear pulse not one-hot"); // R5

    AST_XFER_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_xfer) |-> $past(|hw_done_evt))
        else $error("transfer irq rose without an event"); // R9

    AST_HALT_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.halt_on_err && any_err_evt) |=> halted)
        else $error("halt not taken on error"); // R11

endmodule

// File: tb/dma_chctl_regs_bench.sv
module dma_chctl_regs_bench;

    localparam int NCH = 32;
    localparam logic [31:0] CTRL_MASK = 32'h0003_00FE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        big_endian = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] hw_done_evt = '0;
    logic [NCH-1:0] hw_err_evt = '0;
    logic [NCH-1:0] req_enable, start_pulse, done_clear_pulse;
    logic dbg_enable, arb_rr_chan, arb_rr_group, halt_on_error, halted;
    logic cont_link, minor_map_en, cancel_err_req, cancel_req, irq_xfer, irq_err;

    dma_chctl_regs u_dma_chctl_regs (
        .clk (clk), .rst (rst), .big_endian (big_endian),
        .bus_valid (bus_valid), .bus_write (bus_write), .bus_size (bus_size),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .hw_done_evt (hw_done_evt), .hw_err_evt (hw_err_evt),
        .req_enable (req_enable), .start_pulse (start_pulse),
        .done_clear_pulse (done_clear_pulse),
        .dbg_enable (dbg_enable), .arb_rr_chan (arb_rr_chan),
        .arb_rr_group (arb_rr_group), .halt_on_error (halt_on_error),
        .halted (halted), .cont_link (cont_link), .minor_map_en (minor_map_en),
        .cancel_err_req (cancel_err_req), .cancel_req (cancel_req),
        .irq_xfer (irq_xfer), .irq_err (irq_err)
    );

    always #5 clk = ~clk;

    logic [31:0] m_ctrl = '0, m_req = '0, m_eei = '0, m_int = '0, m_err = '0;
    logic [4:0]  m_chan = '0;
    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sw32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] img(input logic [3:0] idx);
        case (idx)
            4'd0:    return m_ctrl & CTRL_MASK;
            4'd1:    return {(m_err != 0), 26'b0, m_chan};
            4'd3:    return m_req;
            4'd5:    return m_eei;
            4'd9:    return m_int;
            4'd11:   return m_err;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] rd_model(input logic [1:0] sz, input logic [5:0] a, input logic be);
        logic [5:0]  ea = a;
        logic [31:0] w;
        logic [15:0] h;
        if (be && sz == 2'd0) ea = a ^ 6'd3;
        if (be && sz == 2'd1) ea = a ^ 6'd2;
        w = img(ea[5:2]);
        h = ea[1] ? w[31:16] : w[15:0];
        case (sz)
            2'd0:    return {24'b0, 8'(w >> (8 * ea[1:0]))};
            2'd1:    return {16'b0, be ? {h[7:0], h[15:8]} : h};
            2'd2:    return be ? sw32(w) : w;
            default: return 32'h0;
        endcase
    endfunction

    task automatic wr(input logic [1:0] sz, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input logic [1:0] sz, input logic [5:0] a);
        logic [31:0] d;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_size = sz; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
        chk(tag, d, rd_model(sz, a, big_endian));
    endtask

    task automatic evt(input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
        @(negedge clk);
        hw_done_evt = dn; hw_err_evt = er;
        @(negedge clk);
        hw_done_evt = '0; hw_err_evt = '0;
    endtask

    // byte command plus events in the same cycle
    task automatic collide(input logic [5:0] a, input logic [7:0] b,
                           input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_size = 2'd0; bus_addr = a; bus_wdata = {24'b0, b};
        hw_done_evt = dn; hw_err_evt = er;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; hw_done_evt = '0; hw_err_evt = '0;
    endtask

    function automatic logic [4:0] low_idx(input logic [NCH-1:0] v);
        for (int i = 0; i < NCH; i++) if (v[i]) return 5'(i);
        return 5'd0;
    endfunction

    function automatic logic [31:0] ctrl_from_ports();
        logic [31:0] w = '0;
        w[1] = dbg_enable; w[2] = arb_rr_chan; w[3] = arb_rr_group; w[4] = halt_on_error;
        w[5] = halted; w[6] = cont_link; w[7] = minor_map_en;
        w[16] = cancel_err_req; w[17] = cancel_req;
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 12; i++) chk_rd("R1 reset word", 2'd2, 6'(4 * i));
        chk("R1 outputs", {ctrl_from_ports(), 30'b0, irq_xfer, irq_err}, 64'h0);
        chk("R1 pulses", start_pulse | done_clear_pulse | req_enable, 32'h0);

        // R2 request enable set/clear sweep with junk upper bits
        for (int ch = 0; ch < NCH; ch++) begin
            wr(2'd0, 6'h1B, {24'b0, 3'(ch % 8), 5'(ch)});
            m_req[ch] = 1'b1;
            chk("R2 set req", req_enable, m_req);
        end
        chk_rd("R2 req readback", 2'd2, 6'h0C);
        for (int ch = NCH - 1; ch >= 0; ch--) begin
            wr(2'd0, 6'h1A, {24'b0, 3'(7 - ch % 8), 5'(ch)});
            m_req[ch] = 1'b0;
            chk("R2 clr req", req_enable, m_req);
        end

        // R3 error-interrupt enable sweep
        for (int ch = 0; ch < NCH; ch++) begin
            wr(2'd0, 6'h19, {27'b0, 5'(ch)});
            m_eei[ch] = 1'b1;
            chk_rd("R3 set eei", 2'd2, 6'h14);
        end
        chk("R3 req untouched", req_enable, 32'h0);
        for (int ch = 0; ch < NCH; ch++) begin
            wr(2'd0, 6'h18, {27'b0, 5'(ch)});
            m_eei[ch] = 1'b0;
            chk_rd("R3 clr eei", 2'd2, 6'h14);
        end

        // R4 / R9 done events and interrupt clear
        for (int ch = 0; ch < NCH; ch++) begin
            evt(32'(1) << ch, '0);
            m_int[ch] = 1'b1;
            chk("R9 irq_xfer set", {31'b0, irq_xfer}, 32'h1);
            chk_rd("R4 int pending", 2'd2, 6'h24);
            wr(2'd0, 6'h1F, {27'b0, 5'(ch)});
            m_int[ch] = 1'b0;
            chk("R9 irq_xfer clear", {31'b0, irq_xfer}, 32'h0);
        end
        // R4 collisions: event wins over same-bit clear
        evt(32'h20, '0); m_int[5] = 1'b1;
        collide(6'h1F, 8'd5, 32'h20, '0);
        chk_rd("R4 done beats clear", 2'd2, 6'h24);
        collide(6'h1F, 8'd5, 32'h40, '0); m_int[5] = 1'b0; m_int[6] = 1'b1;
        chk_rd("R4 clear with other event", 2'd2, 6'h24);
        wr(2'd0, 6'h1F, 8'd6); m_int[6] = 1'b0;

        // R4 / R9 / R10 error events
        for (int ch = 0; ch < NCH; ch++) begin
            evt('0, 32'(1) << ch);
            m_err[ch] = 1'b1; m_chan = 5'(ch);
            chk_rd("R10 estat set", 2'd2, 6'h04);
            chk("R9 irq_err masked", {31'b0, irq_err}, 32'h0);
            wr(2'd0, 6'h19, {27'b0, 5'(ch)}); m_eei[ch] = 1'b1;
            chk("R9 irq_err enabled", {31'b0, irq_err}, 32'h1);
            wr(2'd0, 6'h1E, {27'b0, 5'(ch)}); m_err[ch] = 1'b0;
            chk_rd("R10 estat cleared", 2'd2, 6'h04);
            chk("R9 irq_err gone", {31'b0, irq_err}, 32'h0);
            wr(2'd0, 6'h18, {27'b0, 5'(ch)}); m_eei[ch] = 1'b0;
        end
        evt('0, 32'h0000_0208); m_err = 32'h208; m_chan = 5'd3;
        chk_rd("R10 lowest index", 2'd2, 6'h04);
        collide(6'h1E, 8'd9, '0, 32'h200); m_chan = 5'd9;
        chk_rd("R4 error beats clear", 2'd2, 6'h2C);
        wr(2'd0, 6'h1E, 8'd9); wr(2'd0, 6'h1E, 8'd3); m_err = '0;
        chk_rd("R10 after clear", 2'd2, 6'h04);

        // R5 pulses
        for (int ch = 0; ch < NCH; ch++) begin
            wr(2'd0, 6'h1D, {27'b0, 5'(ch)});
            chk("R5 start pulse", start_pulse, 32'(1) << ch);
            @(negedge clk);
            chk("R5 start one cycle", start_pulse, 32'h0);
            wr(2'd0, 6'h1C, {27'b0, 5'(ch)});
            chk("R5 done clear pulse", done_clear_pulse, 32'(1) << ch);
            @(negedge clk);
            chk("R5 done clear one cycle", done_clear_pulse, 32'h0);
        end

        // R6 word loads and ignored writes
        wr(2'd2, 6'h0C, 32'hA5A5_0F0F); m_req = 32'hA5A5_0F0F;
        chk("R6 req word load", req_enable, m_req);
        wr(2'd2, 6'h14, 32'h1234_5678); m_eei = 32'h1234_5678;
        chk_rd("R6 eei word load", 2'd2, 6'h14);
        wr(2'd0, 6'h0C, 32'hFF); chk("R6 byte to word reg", req_enable, m_req);
        wr(2'd1, 6'h0E, 32'hFFFF); chk("R6 half to word reg", req_enable, m_req);
        wr(2'd3, 6'h0C, 32'h0); chk("R6 size 3 ignored", req_enable, m_req);
        wr(2'd1, 6'h1A, 32'h0000); chk("R6 half to port", req_enable, m_req);
        wr(2'd2, 6'h24, 32'hFFFF_FFFF); chk_rd("R6 int read-only", 2'd2, 6'h24);
        wr(2'd2, 6'h04, 32'hFFFF_FFFF); chk_rd("R6 estat read-only", 2'd2, 6'h04);
        wr(2'd2, 6'h30, 32'hFFFF_FFFF); wr(2'd2, 6'h08, 32'hFFFF_FFFF);
        chk_rd("R6 unmapped write", 2'd2, 6'h30);
        chk("R6 unmapped leaves req", req_enable, m_req);
        chk("R6 unmapped leaves ctrl", ctrl_from_ports(), 32'h0);

        // R7 control bit sweep
        for (int b = 0; b < 32; b++) begin
            wr(2'd2, 6'h00, 32'(1) << b); m_ctrl = (32'(1) << b) & CTRL_MASK;
            chk_rd("R7 ctrl read", 2'd2, 6'h00);
            chk("R7 ctrl ports", ctrl_from_ports(), m_ctrl);
        end
        wr(2'd2, 6'h00, 32'hFFFF_FFFF); m_ctrl = CTRL_MASK;
        chk("R7 ctrl all", ctrl_from_ports(), CTRL_MASK);

        // R11 halt on error
        wr(2'd2, 6'h00, 32'h10); m_ctrl = 32'h10;
        evt('0, 32'h4); m_ctrl = 32'h30; m_err = 32'h4; m_chan = 5'd2;
        chk("R11 halted", ctrl_from_ports(), 32'h30);
        wr(2'd2, 6'h00, 32'h0); m_ctrl = 32'h0;
        evt('0, 32'h4);
        chk("R11 no halt when off", {31'b0, halted}, 32'h0);
        wr(2'd0, 6'h1E, 8'd2); m_err = '0;

        // R8 big-endian mode
        big_endian = 1'b1;
        wr(2'd2, 6'h0C, 32'h0403_0201); m_req = 32'h0102_0304;
        chk("R8 word swap write", req_enable, m_req);
        wr(2'd0, 6'h18, 8'd7); m_req[7] = 1'b1;
        chk("R8 byte addr swap set", req_enable, m_req);
        wr(2'd2, 6'h14, 32'hFFFF_FFFF); m_eei = 32'hFFFF_FFFF;
        wr(2'd0, 6'h1B, 8'd3); m_eei[3] = 1'b0;
        chk_rd("R8 byte addr swap clear", 2'd2, 6'h14);
        wr(2'd2, 6'h00, 32'h0200_0000); m_ctrl = 32'h2;
        chk("R8 ctrl via swap", {31'b0, dbg_enable}, 32'h1);
        evt(32'h0001_8001, 32'h0100_0010);
        m_int = 32'h0001_8001; m_err = 32'h0100_0010; m_chan = 5'd4;

        // R8 / R12 exhaustive read sweep over both layouts
        for (int be = 0; be < 2; be++) begin
            big_endian = 1'(be);
            for (int sz = 0; sz < 4; sz++)
                for (int a = 0; a < 64; a++)
                    chk_rd("R8 R12 read map", 2'(sz), 6'(a));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule